// File: doc/BRIEF.md
# Quadrature Data Quality Detector

This block judges how clean a demodulated frequency-shift signal is by watching only the sign bits of the I and Q baseband channels. For a clean signal the phasor turns steadily, so edges alternate between the two channels: an I edge, then a Q edge, then an I edge, and so on. The block counts how many such alternating edges arrive in an unbroken run. Any edge that repeats the channel of the one before it, or edges on both channels in the same cycle, break the run and the count falls to zero.

A bit-period strobe, produced elsewhere on the system clock, closes each measurement window. On the strobe the block compares the run count with a small programmable threshold and latches the result into a single good/bad flag. It then restarts the count for the next window. The channel of the last edge is kept across the strobe, so a run that is still going on continues into the next window. When the frequency deviation is close to the bit rate, a clean bit gives about four edges. At lower bit rates more edges fit in one bit, so the count is allowed to grow well past four.

The I and Q sign inputs are asynchronous and go through a two-flop synchronizer. The strobe and the threshold are in the system clock domain. All pins are plain level signals. No input or output of this block carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `qdq_quality_detector`

## Requirements
- R1: The synchronous active-high reset sets `quality_good` to 0 (bad), sets the run count to zero and clears the edge-order reference. The first strobe after reset with threshold 1 therefore gives 0.
- R2: An edge on one channel only, rising or falling, adds one to the run count when the previous edge was on the other channel.
- R3: The first edge after reset, or after a simultaneous-edge break, only sets the order reference (I or Q). It does not add to the count.
- R4: An edge on one channel only, when the previous edge was on that same channel, sets the run count to zero. That edge becomes the new order reference.
- R5: Edges on I and Q in the same cycle set the run count to zero and clear the order reference.
- R6: On a cycle with `bit_strobe` high, `quality_good` takes the value (run count >= `quality_thr`), compared as unsigned numbers. It is visible after that clock edge. A threshold of 0 always gives 1.
- R7: `quality_good` changes only on a strobe cycle or in reset. Edges between strobes do not move it.
- R8: A strobe zeroes the run count for the next window and keeps the order reference. A correct edge seen in the strobe cycle starts the new window at 1. That edge is not part of the window being judged.
- R9: The run count saturates at 255 (2^CNT_W - 1) and does not wrap. After 256 correct edges a threshold of 7 still gives 1.
- R10: Each sign input passes through two synchronizing flops, and one more register is used to find its edge. A change driven just after a clock edge is seen as an edge in the cycle ending at the third clock edge after it, and it updates the count at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| i_sign | input | 1 | Sign bit of the in-phase baseband channel, asynchronous |
| q_sign | input | 1 | Sign bit of the quadrature baseband channel, asynchronous |
| bit_strobe | input | 1 | One-cycle pulse that ends a bit-period window |
| quality_thr | input | THR_W (3) | Minimum run count for a good window |
| quality_good | output | 1 | 1 = last window good, 0 = bad |

## Verification
The bench tests the detector with:
- clean alternating I/Q rotations of different lengths, placed on both sides of the threshold, including exactly 6 and 7 edges against a threshold of 7;
- rotations broken by a repeated-channel edge, and rotations broken by simultaneous I and Q edges;
- a run of 256 correct edges, which tells a saturating counter apart from one that wraps;
- an edge placed so that it is detected in the same cycle as the strobe.

The repeated-channel and simultaneous cases separate "count resets and the edge becomes the reference" from "reference cleared". The strobe-collision case fixes the synchronizer depth, because a shorter chain would count that edge in the window being judged. It also shows the edge carried into the next window.

// File: rtl/qdq_pkg.sv
package qdq_pkg;
  // which channel produced the last accepted edge
  typedef enum logic [1:0] {
    REF_NONE = 2'd0,
    REF_I    = 2'd1,
    REF_Q    = 2'd2
  } ref_ch_e;

  localparam int CH_I = 0;
  localparam int CH_Q = 1;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/qdq_sync.sv
module qdq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/qdq_order.sv
module qdq_order
  import qdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] lvl,
  output logic              run_inc,
  output logic              run_break
);
  logic [NUM_CH-1:0] lvl_d;
  logic [NUM_CH-1:0] chan_edge;
  ref_ch_e           ref_q, ref_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl;
  end

  assign chan_edge = lvl ^ lvl_d;

  always_comb begin
    ref_d     = ref_q;
    run_inc   = 1'b0;
    run_break = 1'b0;
    case (chan_edge)
      2'b11: begin
        run_break = 1'b1;
        ref_d     = REF_NONE;
      end
      2'b01: begin
        if (ref_q == REF_Q)      run_inc   = 1'b1;
        else if (ref_q == REF_I) run_break = 1'b1;
        ref_d = REF_I;
      end
      2'b10: begin
        if (ref_q == REF_I)      run_inc   = 1'b1;
        else if (ref_q == REF_Q) run_break = 1'b1;
        ref_d = REF_Q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= REF_NONE;
    else     ref_q <= ref_d;
  end

  // R3: no count without an established reference
  assert_first_ref_R3: assert property (@(posedge clk) disable iff (rst)
    (ref_q == REF_NONE) |-> !run_inc);

  // R5: after a simultaneous edge pair the reference is empty
  assert_dual_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (&chan_edge) |=> (ref_q == REF_NONE));
endmodule

// File: rtl/qdq_run_cnt.sv
module qdq_run_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  input  logic             brk,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, base;

  always_comb begin
    base = clear ? '0 : cnt_q;
    if (brk)                          cnt_d = '0;
    else if (inc && base != CNT_MAX)  cnt_d = base + 1'b1;
    else                              cnt_d = base;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && inc && !clear && !brk) |=> (cnt_q == CNT_MAX));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!clear && !brk) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  assert_window_restart_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q <= 1));
endmodule

// File: rtl/qdq_quality_detector.sv
module qdq_quality_detector
  import qdq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int THR_W       = 3,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_sign,
  input  logic             q_sign,
  input  logic             bit_strobe,
  input  logic [THR_W-1:0] quality_thr,
  output logic             quality_good
);
  logic [NUM_CH-1:0] raw_lvl, sync_lvl;
  logic              ev_inc, ev_break;
  logic [CNT_W-1:0]  run_cnt;
  logic              flag_q;

  assign raw_lvl[CH_I] = i_sign;
  assign raw_lvl[CH_Q] = q_sign;

  qdq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_lvl),
    .dout (sync_lvl)
  );

  qdq_order u_order (
    .clk       (clk),
    .rst       (rst),
    .lvl       (sync_lvl),
    .run_inc   (ev_inc),
    .run_break (ev_break)
  );

  qdq_run_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (bit_strobe),
    .inc   (ev_inc),
    .brk   (ev_break),
    .count (run_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)             flag_q <= 1'b0;
    else if (bit_strobe) flag_q <= (run_cnt >= CNT_W'(quality_thr));
  end

  assign quality_good = flag_q;

  assert_reset_bad_R1: assert property (@(posedge clk)
    rst |=> !quality_good);

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !bit_strobe |=> $stable(quality_good));

  // R4 and R5: any break from the order tracker empties the counter
  assert_break_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ev_break |=> (run_cnt == '0));
endmodule

// File: tb/qdq_quality_detector_tb_top.sv
module qdq_quality_detector_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       i_in = 1'b0;
  logic       q_in = 1'b0;
  logic       bit_strobe = 1'b0;
  logic [2:0] thresh = 3'd0;
  logic       quality_good;

  int checks = 0;
  int fails  = 0;
  bit last_was_i = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  qdq_quality_detector dut_i (
    .clk          (clk),
    .rst          (rst),
    .i_sign       (i_in),
    .q_sign       (q_in),
    .bit_strobe   (bit_strobe),
    .quality_thr  (thresh),
    .quality_good (quality_good)
  );

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst = 1'b1; i_in = 1'b0; q_in = 1'b0; bit_strobe = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  task automatic tog_i();
    i_in = ~i_in; last_was_i = 1'b1; step(3);
  endtask

  task automatic tog_q();
    q_in = ~q_in; last_was_i = 1'b0; step(3);
  endtask

  task automatic tog_both();
    i_in = ~i_in; q_in = ~q_in; step(3);
  endtask

  task automatic alt_edges(input int n);
    for (int k = 0; k < n; k++) begin
      if (last_was_i) tog_q();
      else            tog_i();
    end
  endtask

  task automatic strobe_chk(input logic [2:0] thr, input logic exp, input string what);
    thresh = thr; bit_strobe = 1'b1;
    step(1);
    bit_strobe = 1'b0;
    check(quality_good, exp, what);
  endtask

  task automatic t_reset();
    reset_dut();
    check(quality_good, 1'b0, "R1 flag bad after reset");
    strobe_chk(3'd1, 1'b0, "R1 count zero after reset");
    strobe_chk(3'd0, 1'b1, "R6 zero threshold is always good");
  endtask

  task automatic t_rotation();
    reset_dut();
    tog_i(); tog_q(); tog_i(); tog_q(); tog_i();
    strobe_chk(3'd4, 1'b1, "R2 four alternating edges meet threshold 4");
    tog_q(); tog_i(); tog_q();
    strobe_chk(3'd4, 1'b0, "R2 three edges miss threshold 4");
  endtask

  task automatic t_first();
    reset_dut();
    tog_q();
    strobe_chk(3'd1, 1'b0, "R3 first edge only sets reference");
  endtask

  task automatic t_same();
    reset_dut();
    tog_i(); tog_q(); tog_i(); tog_i();
    strobe_chk(3'd1, 1'b0, "R4 repeated channel clears run");
    tog_q();
    strobe_chk(3'd1, 1'b1, "R4 repeated edge is new reference");
  endtask

  task automatic t_both();
    reset_dut();
    tog_i(); tog_q(); tog_i();
    tog_both();
    tog_i();
    strobe_chk(3'd1, 1'b0, "R5 dual edge clears count and reference");
    tog_q();
    strobe_chk(3'd1, 1'b1, "R5 reference rebuilt after dual edge");
  endtask

  task automatic t_boundary();
    reset_dut();
    tog_i();
    alt_edges(6);
    strobe_chk(3'd7, 1'b0, "R6 count 6 below threshold 7");
    alt_edges(7);
    strobe_chk(3'd7, 1'b1, "R6 count 7 equals threshold 7");
  endtask

  task automatic t_hold();
    reset_dut();
    tog_i();
    alt_edges(3);
    strobe_chk(3'd3, 1'b1, "R6 count 3 meets threshold 3");
    tog_both();
    step(6);
    check(quality_good, 1'b1, "R7 flag holds through dual edge");
    strobe_chk(3'd7, 1'b0, "R6 empty window misses threshold 7");
    tog_i();
    alt_edges(5);
    check(quality_good, 1'b0, "R7 flag holds through clean edges");
  endtask

  task automatic t_strobe_edge();
    reset_dut();
    tog_i(); tog_q(); tog_i();
    q_in = ~q_in;
    step(2);
    thresh = 3'd3; bit_strobe = 1'b1;
    step(1);
    bit_strobe = 1'b0;
    check(quality_good, 1'b0, "R10 edge in strobe cycle not in judged window");
    step(3);
    strobe_chk(3'd1, 1'b1, "R8 strobe-cycle edge counted in new window");
    strobe_chk(3'd1, 1'b0, "R8 strobe zeroes count");
  endtask

  task automatic t_sat();
    reset_dut();
    tog_i();
    alt_edges(256);
    strobe_chk(3'd7, 1'b1, "R9 count saturates instead of wrapping");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_rotation();
    t_first();
    t_same();
    t_both();
    t_boundary();
    t_hold();
    t_strobe_edge();
    t_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule